// File: doc/BRIEF.md
# Match/Capture Timer

A 32-bit counter with a programmable prescaler, four compare channels and two capture channels. Software reaches it through a word-indexed register port with one-cycle reads and writes. The counter steps on prescaled clock cycles, or on edges of one of the capture inputs.

When the counter sits at a compare value and is about to step, the compare channel can do any mix of three things: set an interrupt flag, send the counter back to zero, and halt counting. Each compare channel also drives one output pin. On a match that pin is held, driven low, driven high or toggled. Each capture channel synchronises its input, detects the selected edges, stores the counter value and can set an interrupt flag. Flags are cleared by writing ones to them. The interrupt line is high while any flag is set.

Top module: `mcap_timer`

## Requirements
- R1: After reset, every register reads 0, `irq` is low and every `match_out` pin is low.
- R2: In clock mode (word 28 bits [1:0] = 0), with run set (word 1 bit 0) and hold clear, the prescale counter (word 4) advances each clock. It wraps to 0 when it equals the prescale limit (word 3), and on that wrap the main counter (word 2) steps once. After k clocks from a zeroed start the counter therefore holds k/(limit+1), rounded down.
- R3: While hold (word 1 bit 1) is set, the main counter and the prescale counter stay 0, whatever the other inputs are.
- R4: Compare channel n fires when the counter equals its compare value (word 6+n) at a step. If bit 3n of word 5 is set, this sets flag bit n of word 0.
- R5: If bit 3n+1 of word 5 is set, the step that fires channel n loads 0 instead of compare+1.
- R6: If bit 3n+2 of word 5 is set, the firing step leaves the counter at the compare value and clears run (word 1 bit 0).
- R7: On firing, channel n applies code bits [2n+5:2n+4] of word 15 to pin n: 0 keep, 1 low, 2 high, 3 toggle. Bits [3:0] of word 15 read and write the pin levels directly.
- R8: Capture channel c passes its input through two flops. A rising edge (bit 3c of word 10 set) or a falling edge (bit 3c+1 set) stores the counter into word 11+c. If bit 3c+2 is set, it also sets flag bit 4+c. Edges that are not selected store nothing.
- R9: Writing a 1 to a flag bit in word 0 clears that bit. `irq` is the OR of all six flags.
- R10: A flag event in the same cycle as a write-one-clear of that flag leaves the flag set.
- R11: With word 28 bits [1:0] = 1, 2 or 3, the counter steps on rising, falling or both edges of the capture input picked by bits [3:2] (0 for input 0, 1 for input 1), through the prescaler. Clock cycles alone do not step it.
- R12: Word indices not listed above read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 6 | Register word index |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from reg_addr |
| cap_in | input | 2 | Capture / count inputs |
| match_out | output | 4 | Compare-driven output pins |
| irq | output | 1 | OR of all flags |

## Verification
A capture event and a software write-one-clear of the same flag can land in one clock edge. The bench provokes this by raising a capture input and then issuing the clear so that it lands on the edge where the synchronised rise is seen. It then expects the flag and `irq` to read 1; a second, isolated clear must drop both. In the same way, a compare step and the hold bit or a software counter write can coincide; the in-RTL properties on counter reset and hold judge those cases.

// File: rtl/mcap_timer_pkg.sv
package mcap_timer_pkg;

   localparam int unsigned REG_IDX_W = 6;
   localparam int unsigned MAX_MATCH = 4;
   localparam int unsigned MAX_CAP   = 2;

   localparam logic [REG_IDX_W-1:0] IDX_FLAGS   = 6'd0;
   localparam logic [REG_IDX_W-1:0] IDX_CTRL    = 6'd1;
   localparam logic [REG_IDX_W-1:0] IDX_COUNT   = 6'd2;
   localparam logic [REG_IDX_W-1:0] IDX_PSLIM   = 6'd3;
   localparam logic [REG_IDX_W-1:0] IDX_PSCNT   = 6'd4;
   localparam logic [REG_IDX_W-1:0] IDX_MACT    = 6'd5;
   localparam logic [REG_IDX_W-1:0] IDX_MVAL0   = 6'd6;
   localparam logic [REG_IDX_W-1:0] IDX_CAPCFG  = 6'd10;
   localparam logic [REG_IDX_W-1:0] IDX_CAPVAL0 = 6'd11;
   localparam logic [REG_IDX_W-1:0] IDX_EXTCFG  = 6'd15;
   localparam logic [REG_IDX_W-1:0] IDX_CNTSRC  = 6'd28;

   typedef enum logic [1:0] {
      EXT_KEEP = 2'd0,
      EXT_LOW  = 2'd1,
      EXT_HIGH = 2'd2,
      EXT_FLIP = 2'd3
   } ext_code_e;

   typedef enum logic [1:0] {
      SRC_CLOCK = 2'd0,
      SRC_RISE  = 2'd1,
      SRC_FALL  = 2'd2,
      SRC_BOTH  = 2'd3
   } cnt_src_e;

   typedef struct packed {
      logic halt;
      logic zero;
      logic flag;
   } match_act_t;

   function automatic logic ext_apply(ext_code_e code, logic cur);
      case (code)
         EXT_LOW:  return 1'b0;
         EXT_HIGH: return 1'b1;
         EXT_FLIP: return ~cur;
         default:  return cur;
      endcase
   endfunction

endpackage

// File: rtl/mcap_edge_sync.sv
module mcap_edge_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic rise,
   output logic fall
);

   if (STAGES < 2) begin : g_bad_stages
      $error("mcap_edge_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
         prev_q  <= 1'b0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], din};
         prev_q  <= chain_q[STAGES-1];
      end
   end

   assign rise = chain_q[STAGES-1] & ~prev_q;
   assign fall = ~chain_q[STAGES-1] & prev_q;

endmodule

// File: rtl/mcap_capture_chan.sv
module mcap_capture_chan #(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rise,
   input  logic             fall,
   input  logic             en_rise,
   input  logic             en_fall,
   input  logic [CNT_W-1:0] count_in,
   output logic [CNT_W-1:0] cap_q,
   output logic             hit
);

   assign hit = (en_rise & rise) | (en_fall & fall);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cap_q <= '0;
      else if (hit) cap_q <= count_in;
   end

   // R8: a selected edge stores the counter value seen in that cycle
   assert_cap_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> (cap_q == $past(count_in)));

   // R8: with no selected edge the stored value holds
   assert_cap_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !hit |=> $stable(cap_q));

endmodule

// File: rtl/mcap_step_gen.sv
module mcap_step_gen
   import mcap_timer_pkg::*;
#(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             hold,
   input  cnt_src_e         src,
   input  logic             ed_rise,
   input  logic             ed_fall,
   input  logic [CNT_W-1:0] limit,
   input  logic             wr_en,
   input  logic [CNT_W-1:0] wr_data,
   output logic [CNT_W-1:0] ps_q,
   output logic             tick
);

   logic step;
   logic wrap;

   always_comb begin
      unique case (src)
         SRC_CLOCK: step = 1'b1;
         SRC_RISE:  step = ed_rise;
         SRC_FALL:  step = ed_fall;
         default:   step = ed_rise | ed_fall;
      endcase
   end

   assign wrap = (ps_q == limit);
   assign tick = run & step & wrap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          ps_q <= '0;
      else if (hold)       ps_q <= '0;
      else if (wr_en)      ps_q <= wr_data;
      else if (run & step) ps_q <= wrap ? '0 : ps_q + 1'b1;
   end

   // R2: a step taken at the limit wraps the prescale counter to zero
   assert_ps_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (run && step && wrap && !wr_en && !hold) |=> (ps_q == '0));

   // R3: hold zeroes the prescale counter
   assert_ps_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> (ps_q == '0));

endmodule

// File: rtl/mcap_match_chan.sv
module mcap_match_chan
   import mcap_timer_pkg::*;
#(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic [CNT_W-1:0] count,
   input  logic [CNT_W-1:0] mval,
   input  match_act_t       act,
   input  ext_code_e        code,
   input  logic             sw_wr,
   input  logic             sw_level,
   output logic             hit,
   output logic             flag_evt,
   output logic             zero_req,
   output logic             halt_req,
   output logic             level_q
);

   logic base;

   assign hit      = tick & (count == mval);
   assign flag_evt = hit & act.flag;
   assign zero_req = hit & act.zero;
   assign halt_req = hit & act.halt;

   assign base = sw_wr ? sw_level : level_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   level_q <= 1'b0;
      else if (hit) level_q <= ext_apply(code, base);
      else          level_q <= base;
   end

   // R7: a firing channel with the drive-high code leaves its pin high
   assert_ext_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && code == EXT_HIGH) |=> level_q);

   // R7: a firing channel with the drive-low code leaves its pin low
   assert_ext_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && code == EXT_LOW) |=> !level_q);

endmodule

// File: rtl/mcap_timer.sv
module mcap_timer
   import mcap_timer_pkg::*;
#(
   parameter int unsigned CNT_W       = 32,
   parameter int unsigned N_MATCH     = 4,
   parameter int unsigned N_CAP       = 2,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [REG_IDX_W-1:0] reg_addr,
   input  logic                 reg_we,
   input  logic [31:0]          reg_wdata,
   output logic [31:0]          reg_rdata,
   input  logic [N_CAP-1:0]     cap_in,
   output logic [N_MATCH-1:0]   match_out,
   output logic                 irq
);

   localparam int unsigned FLAG_W   = MAX_MATCH + MAX_CAP;
   localparam int unsigned MACT_W   = 3 * MAX_MATCH;
   localparam int unsigned CAPCFG_W = 3 * MAX_CAP;
   localparam int unsigned EXT_W    = 2 * MAX_MATCH;

   if (CNT_W < 2 || CNT_W > 32) begin : g_bad_cnt_w
      $error("mcap_timer: CNT_W must lie in 2..32");
   end
   if (N_MATCH < 1 || N_MATCH > MAX_MATCH) begin : g_bad_n_match
      $error("mcap_timer: N_MATCH must lie in 1..4");
   end
   if (N_CAP < 1 || N_CAP > MAX_CAP) begin : g_bad_n_cap
      $error("mcap_timer: N_CAP must lie in 1..2");
   end

   // register state
   logic [1:0]          ctrl_q;
   logic [CNT_W-1:0]    count_q;
   logic [CNT_W-1:0]    pslim_q;
   logic [CNT_W-1:0]    ps_q;
   logic [MACT_W-1:0]   mact_q;
   logic [CNT_W-1:0]    mval_q [MAX_MATCH];
   logic [CAPCFG_W-1:0] capcfg_q;
   logic [EXT_W-1:0]    extcode_q;
   logic [2:0]          cntsrc_q;
   logic [FLAG_W-1:0]   flags_q;

   // channel results
   logic [MAX_MATCH-1:0] m_hit, m_flag, m_zero, m_halt, ext_lvl;
   logic [MAX_CAP-1:0]   c_rise, c_fall, c_hit;
   logic [CNT_W-1:0]     cap_val [MAX_CAP];
   logic [FLAG_W-1:0]    flag_set;

   // write decode
   logic wr_flags, wr_ctrl, wr_count, wr_pslim, wr_pscnt;
   logic wr_mact, wr_capcfg, wr_ext, wr_cntsrc;

   assign wr_flags  = reg_we && (reg_addr == IDX_FLAGS);
   assign wr_ctrl   = reg_we && (reg_addr == IDX_CTRL);
   assign wr_count  = reg_we && (reg_addr == IDX_COUNT);
   assign wr_pslim  = reg_we && (reg_addr == IDX_PSLIM);
   assign wr_pscnt  = reg_we && (reg_addr == IDX_PSCNT);
   assign wr_mact   = reg_we && (reg_addr == IDX_MACT);
   assign wr_capcfg = reg_we && (reg_addr == IDX_CAPCFG);
   assign wr_ext    = reg_we && (reg_addr == IDX_EXTCFG);
   assign wr_cntsrc = reg_we && (reg_addr == IDX_CNTSRC);

   logic run, hold, tick, any_zero, any_halt;
   logic src_rise, src_fall;

   assign hold     = ctrl_q[1];
   assign run      = ctrl_q[0] & ~ctrl_q[1];
   assign any_zero = |m_zero;
   assign any_halt = |m_halt;
   assign src_rise = cntsrc_q[2] ? c_rise[MAX_CAP-1] : c_rise[0];
   assign src_fall = cntsrc_q[2] ? c_fall[MAX_CAP-1] : c_fall[0];

   mcap_step_gen #(.CNT_W(CNT_W)) u_step (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run),
      .hold    (hold),
      .src     (cnt_src_e'(cntsrc_q[1:0])),
      .ed_rise (src_rise),
      .ed_fall (src_fall),
      .limit   (pslim_q),
      .wr_en   (wr_pscnt),
      .wr_data (reg_wdata[CNT_W-1:0]),
      .ps_q    (ps_q),
      .tick    (tick)
   );

   // compare channels
   for (genvar n = 0; n < MAX_MATCH; n++) begin : g_match
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            mval_q[n] <= '0;
         else if (reg_we && reg_addr == REG_IDX_W'(IDX_MVAL0 + n))
            mval_q[n] <= reg_wdata[CNT_W-1:0];
      end

      if (n < N_MATCH) begin : g_live
         mcap_match_chan #(.CNT_W(CNT_W)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick     (tick),
            .count    (count_q),
            .mval     (mval_q[n]),
            .act      (match_act_t'(mact_q[3*n +: 3])),
            .code     (ext_code_e'(extcode_q[2*n +: 2])),
            .sw_wr    (wr_ext),
            .sw_level (reg_wdata[n]),
            .hit      (m_hit[n]),
            .flag_evt (m_flag[n]),
            .zero_req (m_zero[n]),
            .halt_req (m_halt[n]),
            .level_q  (ext_lvl[n])
         );
      end else begin : g_idle
         assign m_hit[n]   = 1'b0;
         assign m_flag[n]  = 1'b0;
         assign m_zero[n]  = 1'b0;
         assign m_halt[n]  = 1'b0;
         assign ext_lvl[n] = 1'b0;
      end
   end

   // capture channels
   for (genvar c = 0; c < MAX_CAP; c++) begin : g_cap
      if (c < N_CAP) begin : g_live
         mcap_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .din   (cap_in[c]),
            .rise  (c_rise[c]),
            .fall  (c_fall[c])
         );
         mcap_capture_chan #(.CNT_W(CNT_W)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .rise     (c_rise[c]),
            .fall     (c_fall[c]),
            .en_rise  (capcfg_q[3*c]),
            .en_fall  (capcfg_q[3*c+1]),
            .count_in (count_q),
            .cap_q    (cap_val[c]),
            .hit      (c_hit[c])
         );
      end else begin : g_idle
         assign c_rise[c]  = 1'b0;
         assign c_fall[c]  = 1'b0;
         assign c_hit[c]   = 1'b0;
         assign cap_val[c] = '0;
      end
   end

   // flag sources: compare channels low, capture channels from bit 4
   always_comb begin
      flag_set = '0;
      for (int n = 0; n < MAX_MATCH; n++) flag_set[n] = m_flag[n];
      for (int c = 0; c < MAX_CAP; c++)
         flag_set[MAX_MATCH+c] = c_hit[c] & capcfg_q[3*c+2];
   end

   // main counter
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        count_q <= '0;
      else if (hold)     count_q <= '0;
      else if (wr_count) count_q <= reg_wdata[CNT_W-1:0];
      else if (tick) begin
         if (any_zero)      count_q <= '0;
         else if (any_halt) count_q <= count_q;
         else               count_q <= count_q + 1'b1;
      end
   end

   // control and configuration registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q    <= '0;
         pslim_q   <= '0;
         mact_q    <= '0;
         capcfg_q  <= '0;
         extcode_q <= '0;
         cntsrc_q  <= '0;
         flags_q   <= '0;
      end else begin
         if (wr_ctrl)   ctrl_q    <= reg_wdata[1:0];
         if (any_halt)  ctrl_q[0] <= 1'b0;
         if (wr_pslim)  pslim_q   <= reg_wdata[CNT_W-1:0];
         if (wr_mact)   mact_q    <= reg_wdata[MACT_W-1:0];
         if (wr_capcfg) capcfg_q  <= reg_wdata[CAPCFG_W-1:0];
         if (wr_ext)    extcode_q <= reg_wdata[4 +: EXT_W];
         if (wr_cntsrc) cntsrc_q  <= reg_wdata[2:0];
         flags_q <= (flags_q & ~(wr_flags ? reg_wdata[FLAG_W-1:0] : '0)) | flag_set;
      end
   end

   // read mux
   always_comb begin
      reg_rdata = '0;
      unique case (reg_addr)
         IDX_FLAGS:   reg_rdata = {{(32-FLAG_W){1'b0}}, flags_q};
         IDX_CTRL:    reg_rdata = {30'b0, ctrl_q};
         IDX_COUNT:   reg_rdata = 32'(count_q);
         IDX_PSLIM:   reg_rdata = 32'(pslim_q);
         IDX_PSCNT:   reg_rdata = 32'(ps_q);
         IDX_MACT:    reg_rdata = {{(32-MACT_W){1'b0}}, mact_q};
         IDX_CAPCFG:  reg_rdata = {{(32-CAPCFG_W){1'b0}}, capcfg_q};
         IDX_EXTCFG:  reg_rdata = {{(28-EXT_W){1'b0}}, extcode_q, ext_lvl};
         IDX_CNTSRC:  reg_rdata = {29'b0, cntsrc_q};
         default: begin
            for (int n = 0; n < MAX_MATCH; n++)
               if (reg_addr == REG_IDX_W'(IDX_MVAL0 + n)) reg_rdata = 32'(mval_q[n]);
            for (int c = 0; c < MAX_CAP; c++)
               if (reg_addr == REG_IDX_W'(IDX_CAPVAL0 + c)) reg_rdata = 32'(cap_val[c]);
         end
      endcase
   end

   assign match_out = ext_lvl[N_MATCH-1:0];
   assign irq       = |flags_q;

   // R3: hold forces the main counter to zero
   assert_hold_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> (count_q == '0));

   // R5: a zeroing compare on a step loads zero
   assert_match_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && any_zero && !hold && !wr_count) |=> (count_q == '0));

   // R6: a halting compare clears the run bit
   assert_halt_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
      any_halt |=> !ctrl_q[0]);

   // R9: a clear of flag 0 with no event in that cycle drops it
   assert_flag_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_flags && reg_wdata[0] && !flag_set[0]) |=> !flags_q[0]);

   // R10: a capture-0 event sets its flag even if cleared in the same cycle
   assert_event_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
      flag_set[MAX_MATCH] |=> flags_q[MAX_MATCH]);

endmodule

// File: tb/mcap_timer_bench.sv
`timescale 1ns/1ps
module mcap_timer_bench;
   import mcap_timer_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [5:0]  reg_addr = '0;
   logic        reg_we = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [1:0]  cap_in = '0;
   logic [3:0]  match_out;
   logic        irq;

   int n_chk = 0;
   int n_err = 0;
   bit done  = 1'b0;

   always #4 clk = ~clk;

   mcap_timer u_mcap_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_addr  (reg_addr),
      .reg_we    (reg_we),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .cap_in    (cap_in),
      .match_out (match_out),
      .irq       (irq)
   );

   // prescale vectors: limit, clocks run, expected counter
   localparam int unsigned VECS [5][3] = '{
      '{0, 10, 10}, '{1, 10, 5}, '{3, 10, 2}, '{4, 9, 1}, '{2, 3, 1}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [5:0] idx, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = idx; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [5:0] idx, output logic [31:0] d);
      reg_addr = idx;
      #1;
      d = reg_rdata;
   endtask

   task automatic restart();
      wr(IDX_CTRL, 32'h2);
      wr(IDX_CTRL, 32'h1);
   endtask

   task automatic clocks(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse(input int c);
      @(negedge clk); cap_in[c] = 1'b1;
      clocks(3);
      cap_in[c] = 1'b0;
      clocks(3);
   endtask

   task automatic finish_run();
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_err++;
         $display("FAIL watchdog expired");
         finish_run();
      end
   end

   initial begin
      logic [31:0] v;
      logic [31:0] c0;
      clocks(3);
      rst_n = 1'b1;
      clocks(1);

      // R1 reset state
      rd(IDX_COUNT, v);  chk("R1 count", v, 0);
      rd(IDX_CTRL, v);   chk("R1 ctrl", v, 0);
      rd(IDX_FLAGS, v);  chk("R1 flags", v, 0);
      rd(IDX_PSLIM, v);  chk("R1 pslim", v, 0);
      chk("R1 irq", {31'b0, irq}, 0);
      chk("R1 match_out", {28'b0, match_out}, 0);

      // R2 prescale table
      for (int i = 0; i < 5; i++) begin
         wr(IDX_PSLIM, VECS[i][0]);
         restart();
         clocks(int'(VECS[i][1]));
         rd(IDX_COUNT, v);
         chk("R2 prescaled count", v, VECS[i][2]);
      end

      // R3 hold keeps both counters at zero (limit still 2)
      wr(IDX_CTRL, 32'h3);
      clocks(5);
      rd(IDX_COUNT, v); chk("R3 count held", v, 0);
      rd(IDX_PSCNT, v); chk("R3 prescale held", v, 0);

      // R4 + R5: channel 0 flags and zeroes at 4
      wr(IDX_CTRL, 0);
      wr(IDX_PSLIM, 0);
      wr(IDX_FLAGS, 32'h3F);
      wr(IDX_MVAL0, 4);
      wr(IDX_MACT, 32'h3);
      restart();
      clocks(4);
      rd(IDX_COUNT, v); chk("R5 count before compare", v, 4);
      rd(IDX_FLAGS, v); chk("R4 flag before compare", v, 0);
      clocks(3);
      rd(IDX_COUNT, v); chk("R5 count wrapped at compare", v, 2);
      rd(IDX_FLAGS, v); chk("R4 compare flag", v, 32'h1);
      chk("R9 irq follows flag", {31'b0, irq}, 1);
      wr(IDX_CTRL, 0);
      wr(IDX_MACT, 0);
      wr(IDX_FLAGS, 32'h3F);
      rd(IDX_FLAGS, v); chk("R9 clear all", v, 0);
      chk("R9 irq low", {31'b0, irq}, 0);

      // R6 channel 1 halts at 3
      wr(IDX_MVAL0 + 6'd1, 3);
      wr(IDX_MACT, 32'h20);
      restart();
      clocks(10);
      rd(IDX_COUNT, v); chk("R6 halted at compare", v, 3);
      rd(IDX_CTRL, v);  chk("R6 run cleared", v, 0);

      // R7 drive high on channel 0
      wr(IDX_MACT, 0);
      wr(IDX_EXTCFG, 32'h20);
      wr(IDX_MVAL0, 2);
      restart();
      clocks(2);
      chk("R7 pin low before compare", {28'b0, match_out}, 0);
      clocks(1);
      chk("R7 drive high", {28'b0, match_out}, 32'h1);
      rd(IDX_EXTCFG, v); chk("R7 readback", v, 32'h21);

      // R7 drive low on channel 0
      wr(IDX_CTRL, 0);
      wr(IDX_EXTCFG, 32'h11);
      chk("R7 direct level write", {28'b0, match_out}, 32'h1);
      restart();
      clocks(3);
      chk("R7 drive low", {28'b0, match_out}, 0);

      // R7 toggle on channel 3, zeroing at 1
      wr(IDX_CTRL, 0);
      wr(IDX_EXTCFG, 32'hC00);
      wr(IDX_MVAL0 + 6'd3, 1);
      wr(IDX_MACT, 32'h400);
      restart();
      clocks(2);
      chk("R7 first toggle", {28'b0, match_out}, 32'h8);
      clocks(2);
      chk("R7 second toggle", {28'b0, match_out}, 0);
      wr(IDX_CTRL, 0);
      wr(IDX_MACT, 0);
      wr(IDX_EXTCFG, 0);

      // R8 capture: ch0 rising+flag, ch1 falling only
      wr(IDX_COUNT, 32'h1234);
      wr(IDX_CAPCFG, 32'h15);
      wr(IDX_FLAGS, 32'h3F);
      @(negedge clk); cap_in[0] = 1'b1;
      clocks(3);
      rd(IDX_CAPVAL0, v); chk("R8 rise capture", v, 32'h1234);
      rd(IDX_FLAGS, v);   chk("R8 capture flag", v, 32'h10);
      wr(IDX_COUNT, 32'h55);
      @(negedge clk); cap_in[1] = 1'b1;
      clocks(3);
      rd(IDX_CAPVAL0 + 6'd1, v); chk("R8 unselected edge ignored", v, 0);
      @(negedge clk); cap_in[1] = 1'b0;
      clocks(3);
      rd(IDX_CAPVAL0 + 6'd1, v); chk("R8 fall capture", v, 32'h55);
      rd(IDX_FLAGS, v);          chk("R8 no flag without enable", v, 32'h10);

      // R9 single clear
      wr(IDX_FLAGS, 32'h10);
      rd(IDX_FLAGS, v); chk("R9 write one clears", v, 0);
      chk("R9 irq drops", {31'b0, irq}, 0);

      // R10 capture event and clear on the same edge
      @(negedge clk); cap_in[0] = 1'b0;
      clocks(4);
      cap_in[0] = 1'b1;
      @(posedge clk);
      @(posedge clk);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = IDX_FLAGS; reg_wdata = 32'h10;
      @(negedge clk);
      reg_we = 1'b0;
      rd(IDX_FLAGS, v); chk("R10 event beats clear", v, 32'h10);
      chk("R10 irq stays", {31'b0, irq}, 1);
      wr(IDX_FLAGS, 32'h10);
      rd(IDX_FLAGS, v); chk("R10 later clear", v, 0);

      // R11 counting edges of input 1
      cap_in = '0;
      wr(IDX_CAPCFG, 0);
      wr(IDX_CNTSRC, 32'h5);
      restart();
      clocks(5);
      rd(IDX_COUNT, v); chk("R11 no clock counting", v, 0);
      pulse(1); pulse(1); pulse(1);
      rd(IDX_COUNT, v); chk("R11 rising edges", v, 3);
      wr(IDX_CNTSRC, 32'h7);
      pulse(1); pulse(1);
      rd(IDX_COUNT, v); chk("R11 both edges", v, 7);
      pulse(0);
      rd(IDX_COUNT, v); chk("R11 other input ignored", v, 7);
      wr(IDX_CTRL, 0);
      wr(IDX_CNTSRC, 0);

      // R12 reserved words
      rd(IDX_COUNT, c0);
      wr(6'd14, 32'hFFFF_FFFF);
      rd(6'd14, v);     chk("R12 reserved reads zero", v, 0);
      rd(IDX_COUNT, v); chk("R12 write had no effect", v, c0);
      rd(6'd40, v);     chk("R12 high reserved zero", v, 0);

      done = 1'b1;
      finish_run();
   end

endmodule